// File: doc/BRIEF.md
# Twin-Predicated Vector Move Sequencer

This block turns one register-to-register move into a sequence of element moves in which the source and the destination each walk under their own predicate mask. The source and destination each have an element counter that advances separately. Each counter jumps over the positions that its own mask disables. The same move can therefore act as a plain copy, a gather, a scatter, a compress or an expand, depending on the masks and on which side is a vector.

A caller pulses `start` with the register numbers, the "is vector" flags, the remapped base numbers, both masks and the vector length. The block then issues one element move per cycle. Each move is a read address and a write address, with a write enable for the register file. A single-cycle `done` marks the end of the sequence. The block holds no register storage.

Top module: `vmv_seq`

## Requirements
- R1: After reset, `busy`, `mv_valid`, `wr_en` and `done` are low, and `rd_addr` and `wr_addr` are zero.
- R2: A `start` sampled while idle latches every operand input and sets `busy`. A `start` sampled while `busy` is high has no effect on the running sequence.
- R3: For a side marked as a vector, the address is its base number plus the element index. For a side not marked as a vector, the address is its own register number.
- R4: When the source is a vector, the source index skips every element k whose source mask bit k is 0 before the element is read.
- R5: When the destination is a vector, the destination index skips every element k whose destination mask bit k is 0 before the element is written.
- R6: A scalar side keeps index 0 and its mask is ignored. When both sides are scalar, exactly one move is issued.
- R7: The sequence ends with no further moves as soon as either index has no enabled element left below the vector length. A vector length of 0 gives no moves. Mask bits at or above the vector length are ignored. A vector length above MAXVL is treated as MAXVL.
- R8: Moves are issued one per cycle with no gaps. Move k appears on the (k+2)-th rising edge counting the edge that sampled `start` as the first. `done` is high for exactly one cycle, on the edge after the last move, and `busy` falls on that same edge.
- R9: A move whose write address is 0 keeps `mv_valid` high and forces `wr_en` low. Every other move has `wr_en` high.
- R10: Base plus index is computed modulo the register count, so an address past the last register wraps to the low numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a move sequence (ignored while busy) |
| src_reg | input | REG_W | Source register number |
| dst_reg | input | REG_W | Destination register number |
| src_vec | input | 1 | Source is a vector |
| dst_vec | input | 1 | Destination is a vector |
| src_base | input | REG_W | Remapped base number for a vector source |
| dst_base | input | REG_W | Remapped base number for a vector destination |
| src_pmask | input | MAXVL | Source predicate, bit k enables element k |
| dst_pmask | input | MAXVL | Destination predicate, bit k enables element k |
| vlen | input | IDX_W | Vector length |
| busy | output | 1 | Sequence in progress |
| mv_valid | output | 1 | An element move is presented this cycle |
| rd_addr | output | REG_W | Register-file read address |
| wr_addr | output | REG_W | Register-file write address |
| wr_en | output | 1 | Register-file write enable |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench sweeps every pair of 4-bit masks against every vector length from 0 to one past the maximum, under all four scalar/vector combinations. It compares each cycle's outputs with a list of moves computed arithmetically. A design that skipped on the wrong side, or that ran its indices in lockstep, would emit the wrong address pairs once the two masks differ. A design that honoured mask bits above the vector length, or that missed the clamp, would emit extra moves in the short-length and over-length runs. Bases near the top of the register range check the address wrap. A destination base or register of 0 checks that the write is suppressed while the move still counts. A second `start` with scrambled operands is sent inside every run, and a design that restarted on it would change the sequence.

// File: rtl/vmv_pkg.sv
package vmv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vmv_state_e;
endpackage

// File: rtl/vmv_next_sel.sv
module vmv_next_sel #(
  parameter int MAXVL = 8,
  parameter int IDX_W = 4
) (
  input  logic [MAXVL-1:0] mask,
  input  logic [IDX_W-1:0] from,
  input  logic [IDX_W-1:0] limit,
  input  logic             skip_en,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [MAXVL-1:0] hit;

  genvar k;
  generate
    for (k = 0; k < MAXVL; k++) begin : g_hit
      assign hit[k] = mask[k] && (IDX_W'(k) >= from) && (IDX_W'(k) < limit);
    end
  endgenerate

  always_comb begin
    if (!skip_en) begin
      found = (from < limit);
      idx   = from;
    end else begin
      found = |hit;
      idx   = '0;
      for (int n = MAXVL - 1; n >= 0; n--) begin
        if (hit[n]) idx = IDX_W'(n);
      end
    end
  end
endmodule

// File: rtl/vmv_addr_map.sv
module vmv_addr_map #(
  parameter int REG_W = 5,
  parameter int IDX_W = 4
) (
  input  logic [REG_W-1:0] reg_num,
  input  logic [REG_W-1:0] base,
  input  logic             is_vec,
  input  logic [IDX_W-1:0] idx,
  output logic [REG_W-1:0] addr
);
  logic [REG_W-1:0] idx_r;
  assign idx_r = REG_W'(idx);
  assign addr  = is_vec ? (base + idx_r) : reg_num;
endmodule

// File: rtl/vmv_seq.sv
module vmv_seq
  import vmv_pkg::*;
#(
  parameter  int NREG  = 32,
  parameter  int MAXVL = 8,
  localparam int REG_W = $clog2(NREG),
  localparam int IDX_W = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [REG_W-1:0] src_reg,
  input  logic [REG_W-1:0] dst_reg,
  input  logic             src_vec,
  input  logic             dst_vec,
  input  logic [REG_W-1:0] src_base,
  input  logic [REG_W-1:0] dst_base,
  input  logic [MAXVL-1:0] src_pmask,
  input  logic [MAXVL-1:0] dst_pmask,
  input  logic [IDX_W-1:0] vlen,
  output logic             busy,
  output logic             mv_valid,
  output logic [REG_W-1:0] rd_addr,
  output logic [REG_W-1:0] wr_addr,
  output logic             wr_en,
  output logic             done
);
  localparam logic [IDX_W-1:0] VL_MAX = IDX_W'(MAXVL);

  vmv_state_e       state_q;
  logic [REG_W-1:0] sreg_q, dreg_q, sbase_q, dbase_q;
  logic             svec_q, dvec_q, exh_q;
  logic [MAXVL-1:0] smask_q, dmask_q;
  logic [IDX_W-1:0] vl_q, i_q, j_q;

  logic             s_found, d_found, go;
  logic [IDX_W-1:0] s_idx, d_idx;
  logic [REG_W-1:0] s_addr, d_addr;

  vmv_next_sel #(.MAXVL(MAXVL), .IDX_W(IDX_W)) u_src_sel (
    .mask(smask_q), .from(i_q), .limit(vl_q), .skip_en(svec_q),
    .found(s_found), .idx(s_idx)
  );

  vmv_next_sel #(.MAXVL(MAXVL), .IDX_W(IDX_W)) u_dst_sel (
    .mask(dmask_q), .from(j_q), .limit(vl_q), .skip_en(dvec_q),
    .found(d_found), .idx(d_idx)
  );

  vmv_addr_map #(.REG_W(REG_W), .IDX_W(IDX_W)) u_src_map (
    .reg_num(sreg_q), .base(sbase_q), .is_vec(svec_q), .idx(s_idx),
    .addr(s_addr)
  );

  vmv_addr_map #(.REG_W(REG_W), .IDX_W(IDX_W)) u_dst_map (
    .reg_num(dreg_q), .base(dbase_q), .is_vec(dvec_q), .idx(d_idx),
    .addr(d_addr)
  );

  assign go   = (state_q == ST_RUN) && !exh_q && s_found && d_found;
  assign busy = (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      sreg_q   <= '0;
      dreg_q   <= '0;
      sbase_q  <= '0;
      dbase_q  <= '0;
      svec_q   <= 1'b0;
      dvec_q   <= 1'b0;
      smask_q  <= '0;
      dmask_q  <= '0;
      vl_q     <= '0;
      i_q      <= '0;
      j_q      <= '0;
      exh_q    <= 1'b0;
      mv_valid <= 1'b0;
      wr_en    <= 1'b0;
      rd_addr  <= '0;
      wr_addr  <= '0;
      done     <= 1'b0;
    end else begin
      mv_valid <= 1'b0;
      wr_en    <= 1'b0;
      done     <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start) begin
          state_q <= ST_RUN;
          sreg_q  <= src_reg;
          dreg_q  <= dst_reg;
          sbase_q <= src_base;
          dbase_q <= dst_base;
          svec_q  <= src_vec;
          dvec_q  <= dst_vec;
          smask_q <= src_pmask;
          dmask_q <= dst_pmask;
          vl_q    <= (vlen > VL_MAX) ? VL_MAX : vlen;
          i_q     <= '0;
          j_q     <= '0;
          exh_q   <= 1'b0;
        end
      end else if (go) begin
        mv_valid <= 1'b1;
        rd_addr  <= s_addr;
        wr_addr  <= d_addr;
        wr_en    <= (d_addr != '0);
        if (svec_q) i_q <= s_idx + 1'b1;
        if (dvec_q) j_q <= d_idx + 1'b1;
        if (!svec_q && !dvec_q) exh_q <= 1'b1;
      end else begin
        state_q <= ST_IDLE;
        done    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vmv_seq_chk.sv
module vmv_seq_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             mv_valid,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_addr,
  input logic             done
);
  AST_WR_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr != '0)); // R9

  AST_WR_NEEDS_MOVE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> mv_valid); // R9

  AST_MOVE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    mv_valid |-> busy); // R8

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !mv_valid); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R2
endmodule

bind vmv_seq vmv_seq_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .mv_valid(mv_valid),
  .wr_en(wr_en), .wr_addr(wr_addr), .done(done)
);

// File: tb/sim_vmv_seq.sv
module sim_vmv_seq;
  localparam int NREG  = 32;
  localparam int MAXVL = 4;
  localparam int REG_W = 5;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [REG_W-1:0] src_reg = '0, dst_reg = '0, src_base = '0, dst_base = '0;
  logic             src_vec = 1'b0, dst_vec = 1'b0;
  logic [MAXVL-1:0] src_pmask = '0, dst_pmask = '0;
  logic [IDX_W-1:0] vlen = '0;
  logic             busy, mv_valid, wr_en, done;
  logic [REG_W-1:0] rd_addr, wr_addr;

  int checks = 0;
  int fails  = 0;
  int exp_n;
  int exp_rd [0:7];
  int exp_wr [0:7];

  always #10 clk = ~clk;

  vmv_seq #(.NREG(NREG), .MAXVL(MAXVL)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .src_reg(src_reg), .dst_reg(dst_reg), .src_vec(src_vec), .dst_vec(dst_vec),
    .src_base(src_base), .dst_base(dst_base),
    .src_pmask(src_pmask), .dst_pmask(dst_pmask), .vlen(vlen),
    .busy(busy), .mv_valid(mv_valid), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .wr_en(wr_en), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int vl, input int sm, input int dm, input bit sv,
                       input bit dv, input int sr, input int dr, input int sb,
                       input int db);
    int i = 0;
    int j = 0;
    int l = (vl > MAXVL) ? MAXVL : vl;
    exp_n = 0;
    while (i < l && j < l) begin
      if (sv) while (i < l && ((sm >> i) & 1) == 0) i++;
      if (dv) while (j < l && ((dm >> j) & 1) == 0) j++;
      if (i >= l || j >= l) break;
      exp_rd[exp_n] = sv ? (sb + i) % NREG : sr;
      exp_wr[exp_n] = dv ? (db + j) % NREG : dr;
      exp_n++;
      if (sv) i++;
      if (dv) j++;
      if (!sv && !dv) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mv_valid && !wr_en && !done && rd_addr == 0 && wr_addr == 0,
        "R1 reset state", int'(busy) + int'(mv_valid) + int'(done), 0);

    for (int vl = 0; vl <= MAXVL + 1; vl++) begin
      for (int sm = 0; sm < 16; sm++) begin
        for (int dm = 0; dm < 16; dm++) begin
          for (int mode = 0; mode < 4; mode++) begin
            bit sv = mode[0];
            bit dv = mode[1];
            int sr = (sm + mode) % NREG;
            int dr = ((sm + dm) % 3 == 0) ? 0 : 9;
            int sb = (sm * 3 + vl + 20) % NREG;
            int db = (dm * 7 + mode) % NREG;
            string rtag = sv ? "R4 R3 R10" : "R6 R3";
            string wtag = dv ? "R5 R3 R10" : "R6 R3";
            model(vl, sm, dm, sv, dv, sr, dr, sb, db);
            src_reg = REG_W'(sr); dst_reg = REG_W'(dr);
            src_base = REG_W'(sb); dst_base = REG_W'(db);
            src_vec = sv; dst_vec = dv;
            src_pmask = MAXVL'(sm); dst_pmask = MAXVL'(dm);
            vlen = IDX_W'(vl);
            start = 1'b1;
            @(negedge clk);
            // scrambled second start while busy: must be ignored (R2)
            src_pmask = ~src_pmask; dst_pmask = ~dst_pmask;
            src_vec = ~sv; dst_vec = ~dv; vlen = IDX_W'(MAXVL);
            src_base = src_base + 5'd1; dst_reg = 5'd3;
            @(negedge clk);
            start = 1'b0;
            for (int c = 1; c <= exp_n + 1; c++) begin
              if (c > 1) @(negedge clk);
              if (c <= exp_n) begin
                chk(mv_valid && !done, "R8 R7 R2 move present", int'(mv_valid), 1);
                chk(rd_addr == REG_W'(exp_rd[c-1]), rtag, int'(rd_addr), exp_rd[c-1]);
                chk(wr_addr == REG_W'(exp_wr[c-1]), wtag, int'(wr_addr), exp_wr[c-1]);
                chk(wr_en == (exp_wr[c-1] != 0), "R9 write enable", int'(wr_en),
                    int'(exp_wr[c-1] != 0));
              end else begin
                chk(done && !mv_valid && !busy, "R7 R8 end of sequence",
                    int'(done), 1);
              end
            end
            @(negedge clk);
            chk(!done && !busy && !mv_valid, "R8 R2 idle after done",
                int'(done) + int'(busy), 0);
          end
        end
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule